// File: doc/BRIEF.md
# Sync Polarity and Direction Unit

This block sits at the edge of a pixel interface and owns the horizontal and vertical sync lines. A 4-bit control word, loaded through a simple write port, sets the active level of each sync, whether the two sync pins are sampled or driven, and whether sync timing is taken from the pins or from strobes raised by an embedded-code decoder elsewhere in the pixel path.

When the syncs are inputs, the block turns the pin levels into internal active-high levels and emits a one-clock start strobe at each leading edge. When the syncs are outputs, the block builds the pulses itself. A line-start event opens a horizontal pulse that lasts exactly 64 pixel clocks. A frame-start event opens a vertical pulse that lasts exactly two lines. Each pin is driven at the level the control word selects, and the output enables are raised only in this mode.

Embedded timing is only meaningful for a YCrCb pixel format. If it is requested while the format flag says otherwise, the block keeps using the pins and raises an error flag.

Top module: `sync_port_unit`

## Requirements
- R1: After reset the control word is 0: both output enables are low, `hActive`, `vActive`, `hStart`, `vStart` and `embErr` are low, and the syncs are active-low pin inputs.
- R2: Control bit 0 sets the hsync level. With 0 the active level is low and with 1 it is high. This holds for the pin as sampled in input mode and for the level driven on `hsyncOut` in output mode.
- R3: Control bit 1 sets the vsync active level in the same way, for `vsyncIn` and `vsyncOut`.
- R4: Control bit 2 sets the direction. With 0 both syncs are inputs and `hsyncOe`/`vsyncOe` are low. With 1 both syncs are outputs and both enables are high.
- R5: In pin input mode, `hActive`/`vActive` follow the active-high sync level one clock after it is sampled. `hStart`/`vStart` pulse for exactly one clock at each leading edge, in the same cycle that the active level first shows.
- R6: In output mode, a `lineStart` sampled at a clock edge makes hsync active from that edge for exactly 64 clocks. A `lineStart` that arrives during a pulse restarts the 64-clock count. `hStart` pulses in the pulse's first cycle.
- R7: In output mode, a `frameStart` sampled at an edge makes vsync active from that edge. The pulse ends at the edge that samples the second `lineStart` after it, so it spans two lines.
- R8: With control bit 3 set, bit 2 clear and `ycbcrFmt` high, `hStart`/`vStart` repeat `embHStrobe`/`embVStrobe` one clock later. The sync pins have no effect, and `hActive`/`vActive` stay low.
- R9: In output mode, control bit 3 has no effect. `embErr` stays low, the pins are not sampled, and the pulses are generated as in R6 and R7.
- R10: With control bit 3 set, bit 2 clear and `ycbcrFmt` low, `embErr` is high and sync is taken from the pins as in R5. The embedded strobes are then ignored.
- R11: The control word changes only at a clock edge where `cfgWrEn` is high, taking `cfgWrData[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control word write enable |
| cfgWrData | input | 4 | Control word: bit0 hsync level, bit1 vsync level, bit2 drive, bit3 embedded source |
| ycbcrFmt | input | 1 | High when the pixel format is YCrCb |
| lineStart | input | 1 | Internal one-clock line start event |
| frameStart | input | 1 | Internal one-clock frame start event |
| hsyncIn | input | 1 | Hsync pin, input side |
| vsyncIn | input | 1 | Vsync pin, input side |
| embHStrobe | input | 1 | Hsync start decoded from embedded codes |
| embVStrobe | input | 1 | Vsync start decoded from embedded codes |
| hsyncOut | output | 1 | Hsync pin, driven level |
| vsyncOut | output | 1 | Vsync pin, driven level |
| hsyncOe | output | 1 | Hsync pin output enable |
| vsyncOe | output | 1 | Vsync pin output enable |
| hActive | output | 1 | Internal active-high hsync level |
| vActive | output | 1 | Internal active-high vsync level |
| hStart | output | 1 | One-clock hsync start strobe |
| vStart | output | 1 | One-clock vsync start strobe |
| embErr | output | 1 | Embedded source requested with a non-YCrCb format |

## Verification
A control write takes effect at the edge that samples it. `embErr` and the output enables are decoded from that register, and `embErr` also follows `ycbcrFmt` within the same cycle. Every other result is due one clock after its cause: pin levels, embedded strobes and `lineStart`/`frameStart` are registered once before they appear on `hActive`, `hStart` or the driven pins. The bench changes inputs on the falling edge and compares outputs on the next falling edge, so each check sees the values produced by exactly one rising edge. Pulse widths are measured by counting the falling edges that find the pin at its active level.

// File: rtl/sync_port_pkg.sv
package sync_port_pkg;

  // Control word layout, bit 0 first: hsync level, vsync level, drive, embedded source
  typedef struct packed {
    logic embSel;
    logic drive;
    logic vPol;
    logic hPol;
  } cfgT;

  localparam int CFG_W = $bits(cfgT);
  localparam int NUM_CH = 2;   // channel 0: horizontal, channel 1: vertical

  // Strobes and selects handed from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] pol;
    logic              drive;
    logic              srcEmb;
    logic              srcPin;
    logic [NUM_CH-1:0] trig;
    logic [NUM_CH-1:0] tick;
  } ctlStrobeT;

endpackage

// File: rtl/sync_port_ctrl.sv
module sync_port_ctrl
  import sync_port_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             ycbcrFmt,
  input  logic             lineStart,
  input  logic             frameStart,
  output ctlStrobeT        ctl,
  output logic             embErr
);

  cfgT  cfgQ;
  logic wantEmb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgT'(cfgWrData);
  end

  // The embedded source request only counts while the pins are inputs
  assign wantEmb = cfgQ.embSel & ~cfgQ.drive;

  always_comb begin
    ctl.pol    = {cfgQ.vPol, cfgQ.hPol};
    ctl.drive  = cfgQ.drive;
    ctl.srcEmb = wantEmb & ycbcrFmt;
    ctl.srcPin = ~cfgQ.drive & ~(wantEmb & ycbcrFmt);
    ctl.trig   = {frameStart & cfgQ.drive, lineStart & cfgQ.drive};
    // horizontal counts pixel clocks, vertical counts line starts
    ctl.tick   = {lineStart & cfgQ.drive, cfgQ.drive};
  end

  assign embErr = wantEmb & ~ycbcrFmt;

  // R4: direction bit written reaches the datapath select
  p_dir_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> ctl.drive == $past(cfgWrData[2]));

  // R10: embedded request with non-YCrCb format flags an error
  p_emb_fallback_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgWrEn && cfgWrData[3] && !cfgWrData[2]) && !ycbcrFmt) |-> embErr);

  // R9: no error while the syncs are driven
  p_no_err_drive_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drive |-> !embErr);

endmodule

// File: rtl/sync_port_dp.sv
module sync_port_dp
  import sync_port_pkg::*;
#(
  parameter int HPW = 64,
  parameter int VPW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [NUM_CH-1:0] syncIn,
  input  logic [NUM_CH-1:0] embStb,
  output logic [NUM_CH-1:0] syncOut,
  output logic [NUM_CH-1:0] syncOe,
  output logic [NUM_CH-1:0] act,
  output logic [NUM_CH-1:0] start
);

  localparam int MAXW = (HPW > VPW) ? HPW : VPW;
  localparam int CW   = $clog2(MAXW) + 1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int W = (i == 0) ? HPW : VPW;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          lvl;
    logic          actQ;
    logic          genQ;
    logic          startQ;
    logic [CW-1:0] cntQ;

    // active-high view of the pin
    assign lvl = (syncIn[i] == ctl.pol[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        genQ   <= 1'b0;
        cntQ   <= '0;
        actQ   <= 1'b0;
        startQ <= 1'b0;
      end else begin
        // fixed-width pulse generator, restartable
        if (!ctl.drive) begin
          genQ <= 1'b0;
          cntQ <= '0;
        end else if (ctl.trig[i]) begin
          genQ <= 1'b1;
          cntQ <= LAST;
        end else if (genQ && ctl.tick[i]) begin
          if (cntQ == '0) genQ <= 1'b0;
          else            cntQ <= cntQ - 1'b1;
        end
        // sampled pin level
        actQ <= ctl.srcPin ? lvl : 1'b0;
        // start strobe per source
        if (ctl.drive)       startQ <= ctl.trig[i];
        else if (ctl.srcEmb) startQ <= embStb[i];
        else                 startQ <= lvl & ~actQ;
      end
    end

    assign act[i]     = ctl.drive ? genQ : actQ;
    assign start[i]   = startQ;
    assign syncOut[i] = genQ ? ctl.pol[i] : ~ctl.pol[i];
    assign syncOe[i]  = ctl.drive;

    // R5: a pin-derived start lasts one clock
    p_start_once_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(ctl.srcPin) && startQ && ctl.srcPin) ##1 ctl.srcPin |-> !startQ);

    // R8: embedded strobes pass through with one clock of delay
    p_emb_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctl.srcEmb) |-> startQ == $past(embStb[i]));
  end

endmodule

// File: rtl/sync_port_unit.sv
module sync_port_unit
  import sync_port_pkg::*;
#(
  parameter int HPW = 64,
  parameter int VPW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             ycbcrFmt,
  input  logic             lineStart,
  input  logic             frameStart,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             embHStrobe,
  input  logic             embVStrobe,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             hsyncOe,
  output logic             vsyncOe,
  output logic             hActive,
  output logic             vActive,
  output logic             hStart,
  output logic             vStart,
  output logic             embErr
);

  ctlStrobeT         ctl;
  logic [NUM_CH-1:0] syncOutV;
  logic [NUM_CH-1:0] syncOeV;
  logic [NUM_CH-1:0] actV;
  logic [NUM_CH-1:0] startV;

  sync_port_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .ycbcrFmt   (ycbcrFmt),
    .lineStart  (lineStart),
    .frameStart (frameStart),
    .ctl        (ctl),
    .embErr     (embErr)
  );

  sync_port_dp #(.HPW(HPW), .VPW(VPW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .syncIn  ({vsyncIn, hsyncIn}),
    .embStb  ({embVStrobe, embHStrobe}),
    .syncOut (syncOutV),
    .syncOe  (syncOeV),
    .act     (actV),
    .start   (startV)
  );

  assign hsyncOut = syncOutV[0];
  assign vsyncOut = syncOutV[1];
  assign hsyncOe  = syncOeV[0];
  assign vsyncOe  = syncOeV[1];
  assign hActive  = actV[0];
  assign vActive  = actV[1];
  assign hStart   = startV[0];
  assign vStart   = startV[1];

  // Run-length counter observing the ports, for the width check
  logic [15:0] hRunQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hRunQ <= '0;
    else if (hStart)  hRunQ <= 16'd1;
    else if (hActive) hRunQ <= hRunQ + 16'd1;
  end

  // R6: a driven hsync pulse that ends undisturbed lasted HPW clocks
  p_hwidth_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hsyncOe && $past(hsyncOe) && $fell(hActive)) |-> hRunQ == 16'(HPW));

  // R4: both enables track the one direction bit
  p_oe_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    hsyncOe == vsyncOe);

endmodule

// File: tb/sync_port_unit_tb_top.sv
module sync_port_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = 4'd0;
  logic ycbcrFmt = 1'b0;
  logic lineStart = 1'b0;
  logic frameStart = 1'b0;
  logic hsyncIn = 1'b1;
  logic vsyncIn = 1'b1;
  logic embHStrobe = 1'b0;
  logic embVStrobe = 1'b0;
  logic hsyncOut, vsyncOut, hsyncOe, vsyncOe;
  logic hActive, vActive, hStart, vStart, embErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  sync_port_unit dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ycbcrFmt(ycbcrFmt), .lineStart(lineStart), .frameStart(frameStart),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .embHStrobe(embHStrobe),
    .embVStrobe(embVStrobe), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .hsyncOe(hsyncOe), .vsyncOe(vsyncOe), .hActive(hActive),
    .vActive(vActive), .hStart(hStart), .vStart(vStart), .embErr(embErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrCfg(input logic [3:0] v);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  // active-high level expected from a pin value and a level select bit
  function automatic logic expLvl(input logic pin, input logic pol);
    return pin == pol;
  endfunction

  // counts cycles the pin stays at its active level
  task automatic measure(input logic pinH, input logic pol, output int n);
    n = 0;
    while (((pinH ? hsyncOut : vsyncOut) == pol) && n < 300) begin
      n++;
      tick();
    end
  endtask

  task automatic pulseLine();
    lineStart = 1'b1;
    tick();
    lineStart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic mH, mV, lH, lV;
    void'($urandom(32'd20240607));
    @(negedge clk);
    tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 hsyncOe", hsyncOe, 0);
    chk("R1 vsyncOe", vsyncOe, 0);
    chk("R1 hActive", hActive, 0);
    chk("R1 vActive", vActive, 0);
    chk("R1 hStart", hStart, 0);
    chk("R1 vStart", vStart, 0);
    chk("R1 embErr", embErr, 0);

    // R2/R5 default active-low hsync
    hsyncIn = 1'b0;
    tick();
    chk("R2 low-active hActive", hActive, 1);
    chk("R5 hStart leading edge", hStart, 1);
    tick();
    chk("R5 hStart single clock", hStart, 0);
    chk("R5 hActive held", hActive, 1);
    hsyncIn = 1'b1;
    tick();
    chk("R5 hActive release", hActive, 0);

    // R2 R3 R5: random pin traffic for every level combination
    for (int p = 0; p < 4; p++) begin
      logic [3:0] pv;
      pv = 4'(p);
      wrCfg(pv);
      hsyncIn = ~pv[0];
      vsyncIn = ~pv[1];
      tick();
      tick();
      mH = 1'b0;
      mV = 1'b0;
      chk("R2 idle hActive", hActive, 0);
      chk("R3 idle vActive", vActive, 0);
      for (int k = 0; k < 200; k++) begin
        hsyncIn = 1'($urandom % 2);
        vsyncIn = 1'($urandom % 2);
        lH = expLvl(hsyncIn, pv[0]);
        lV = expLvl(vsyncIn, pv[1]);
        tick();
        chk("R2 hActive", hActive, int'(lH));
        chk("R3 vActive", vActive, int'(lV));
        chk("R5 hStart", hStart, int'(lH & ~mH));
        chk("R5 vStart", vStart, int'(lV & ~mV));
        mH = lH;
        mV = lV;
      end
    end
    hsyncIn = 1'b1;
    vsyncIn = 1'b1;

    // R4 R6 R2: driven mode, hsync active high
    wrCfg(4'b0101);
    chk("R4 hsyncOe", hsyncOe, 1);
    chk("R4 vsyncOe", vsyncOe, 1);
    chk("R2 driven idle level", hsyncOut, 0);
    pulseLine();
    chk("R6 hStart", hStart, 1);
    chk("R6 hActive", hActive, 1);
    measure(1'b1, 1'b1, n);
    chk("R6 width 64 high", n, 64);
    chk("R2 driven back to idle", hsyncOut, 0);

    // R6 R2: active-low output and restart during a pulse
    wrCfg(4'b0100);
    chk("R2 driven idle level low-active", hsyncOut, 1);
    pulseLine();
    repeat (29) tick();
    chk("R6 mid pulse", hsyncOut, 0);
    pulseLine();
    chk("R6 restart hStart", hStart, 1);
    measure(1'b1, 1'b0, n);
    chk("R6 width after restart", n, 64);

    // R7 R3: vsync spans two lines
    wrCfg(4'b0110);
    chk("R3 vsync idle", vsyncOut, 0);
    frameStart = 1'b1;
    lineStart = 1'b1;
    tick();
    frameStart = 1'b0;
    lineStart = 1'b0;
    chk("R7 vStart", vStart, 1);
    chk("R7 vsync on", vsyncOut, 1);
    repeat (20) tick();
    chk("R7 vsync line0", vsyncOut, 1);
    pulseLine();
    chk("R7 vsync after first line", vsyncOut, 1);
    repeat (20) tick();
    chk("R7 vsync line1", vsyncOut, 1);
    pulseLine();
    chk("R7 vsync off after second line", vsyncOut, 0);
    chk("R7 vActive off", vActive, 0);

    // R9: embedded bit ignored while driving
    ycbcrFmt = 1'b0;
    wrCfg(4'b1100);
    chk("R9 embErr low", embErr, 0);
    chk("R9 oe", hsyncOe, 1);
    repeat (70) tick();
    hsyncIn = 1'b0;
    embHStrobe = 1'b1;
    tick();
    embHStrobe = 1'b0;
    chk("R9 pin and strobe ignored", hStart, 0);
    hsyncIn = 1'b1;
    pulseLine();
    measure(1'b1, 1'b0, n);
    chk("R9 width unchanged", n, 64);

    // R8: embedded source with YCrCb
    ycbcrFmt = 1'b1;
    wrCfg(4'b1000);
    tick();
    chk("R8 embErr low", embErr, 0);
    embHStrobe = 1'b1;
    tick();
    embHStrobe = 1'b0;
    chk("R8 hStart follows strobe", hStart, 1);
    chk("R8 hActive low", hActive, 0);
    tick();
    chk("R8 hStart drops", hStart, 0);
    hsyncIn = 1'b0;
    tick();
    chk("R8 pin ignored start", hStart, 0);
    chk("R8 pin ignored active", hActive, 0);
    hsyncIn = 1'b1;
    embVStrobe = 1'b1;
    tick();
    embVStrobe = 1'b0;
    chk("R8 vStart follows strobe", vStart, 1);
    chk("R8 no hStart", hStart, 0);

    // R10: embedded with non-YCrCb falls back to pins
    ycbcrFmt = 1'b0;
    tick();
    chk("R10 embErr high", embErr, 1);
    hsyncIn = 1'b0;
    tick();
    chk("R10 pin hStart", hStart, 1);
    chk("R10 pin hActive", hActive, 1);
    hsyncIn = 1'b1;
    tick();
    embHStrobe = 1'b1;
    tick();
    embHStrobe = 1'b0;
    chk("R10 strobe ignored", hStart, 0);

    // R11: data without enable leaves the word alone
    cfgWrData = 4'b0100;
    tick();
    tick();
    chk("R11 no write oe", hsyncOe, 0);
    chk("R11 no write embErr", embErr, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule